// File: doc/BRIEF.md
# DLL Lock and Tuning-Step Controller

This block brings up the delay-locked loop of a storage-card PHY before high-speed sampling-point tuning. When a start strobe arrives, the block first checks the card clock. If the clock is not in the high-speed range, the block refuses the request. If the DLL is already running, the block returns at once. Otherwise it writes the DLL control word: enable, fast lock, both 90-degree phase selectors and the variant's update strobe. It then waits for the lock indication, bounded by a timeout counted in ticks of an external timebase.

Once the loop has locked, a multi-cycle restoring divider divides the locked delay value by a programmable divider. A divider of zero is treated as one. The quotient is clamped to the largest value the tuning-step field can hold. That step and a consecutive-pass count are then merged into the tuning-control word, and every other bit of that word keeps its value.

Both control words are held inside the block and start from parameter reset values. All pins are plain control or status pins. No data stream crosses the edge of the block, so there is no valid/ready handshake and no back-pressure.

Top module: `dll_tune_ctrl`

## Requirements
- R1: After reset, `dll_ctrl` equals `DLL_RST`, `tune_ctrl` equals `TUNE_RST`, and `done` and `err` are 0.
- R2: A start seen in idle while `hs_clk` is 0 raises `done` with `err`=1 one cycle later and leaves both control words unchanged.
- R3: A start seen in idle with `hs_clk`=1 and bit 31 of `dll_ctrl` clear writes `dll_ctrl` on that edge. Bit 31 (enable) and bit 5 (fast lock) are set, bit 0 (bypass) is cleared, and all bits not named in R3 to R5 keep their values, including bit 3 (gain).
- R4: The same write loads 6'h1F into both phase fields, bits [21:16] and [29:24].
- R5: With `PHY_NEW`=1 the write sets bit 23 (update strobe) and clears bit 30 (reference-clock select). With `PHY_NEW`=0 it sets bit 30 (update strobe) instead.
- R6: A start seen in idle with `hs_clk`=1 while bit 31 of `dll_ctrl` is already set raises `done` with `err`=0 one cycle later and changes neither control word.
- R7: While waiting for lock, the edge that samples the `TO_TICKS`-th `tick` without `dll_lock` ends the run with `done` and `err`=1, and `tune_ctrl` is unchanged. If `dll_lock` and `tick` are high on the same edge, the lock wins.
- R8: The tuning step equals `dly_val / max(div_val,1)`, clamped to `2**STEP_W-1`.
- R9: The step is written to `tune_ctrl[STEP_LSB +: STEP_W]` and `pass_cnt` to `tune_ctrl[CNT_LSB +: CNT_W]`. All other bits keep their values.
- R10: `done` with `err`=0 is visible after the `DLY_W+2`-th rising edge, counting the edge that first samples `dll_lock` high as the first.
- R11: `done` is a one-cycle pulse. `err` is updated only when a start is accepted or when `done` rises, and it holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled in idle only |
| hs_clk | input | 1 | Card clock is above the high-speed threshold |
| dll_lock | input | 1 | Lock indication from the DLL |
| dly_val | input | DLY_W | Locked delay value from the DLL |
| div_val | input | DIV_W | Tuning-step divider (0 is treated as 1) |
| pass_cnt | input | CNT_W | Consecutive-pass count to store |
| tick | input | 1 | Timeout timebase pulse |
| dll_ctrl | output | 32 | DLL control word |
| tune_ctrl | output | 32 | Tuning control word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last run (1 = refused or timed out) |

## Verification
The refusal and no-op outcomes, and the rewritten DLL word, are due one edge after the start edge. The bench samples them at the falling edge that follows that start edge. Completion after lock takes exactly `DLY_W+2` rising edges. The bench counts edges from the one that first samples the lock and requires `done` on exactly that count, rather than waiting open-endedly. The timeout is checked one tick short of expiry and again right after the final tick. Then the bench sweeps every delay value against every divider in a reduced configuration, with the clamped quotient computed arithmetically.

// File: rtl/dll_tune_pkg.sv
package dll_tune_pkg;
  localparam int REG_W      = 32;
  localparam int EN_BIT     = 31;
  localparam int FAST_BIT   = 5;
  localparam int BYP_BIT    = 0;
  localparam int PH_W       = 6;
  localparam int PH_A_LSB   = 16;
  localparam int PH_B_LSB   = 24;
  localparam int UPD_NEW    = 23;
  localparam int UPD_OLD    = 30;
  localparam int REFSEL_BIT = 30;
  localparam logic [PH_W-1:0] PH_QUARTER = 6'h1F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCK,
    ST_DIV,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/dll_word_gen.sv
module dll_word_gen
  import dll_tune_pkg::*;
#(
  parameter bit PHY_NEW = 1'b1
) (
  input  logic [REG_W-1:0] cur,
  output logic [REG_W-1:0] nxt
);
  logic [REG_W-1:0] base;

  always_comb begin
    base = cur;
    base[EN_BIT]   = 1'b1;
    base[FAST_BIT] = 1'b1;
    base[BYP_BIT]  = 1'b0;
    base[PH_A_LSB +: PH_W] = PH_QUARTER;
    base[PH_B_LSB +: PH_W] = PH_QUARTER;
  end

  generate
    if (PHY_NEW) begin : g_new
      always_comb begin
        nxt = base;
        nxt[REFSEL_BIT] = 1'b0;
        nxt[UPD_NEW]    = 1'b1;
      end
    end else begin : g_old
      always_comb begin
        nxt = base;
        nxt[UPD_OLD] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int TO_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  input  logic lock,
  output logic expired
);
  localparam int TW = $clog2(TO_TICKS + 1);
  logic [TW-1:0] cnt_q;
  logic          step;

  assign step    = run && tick && !lock;
  assign expired = step && (cnt_q == TW'(TO_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tune_divider.sv
module tune_divider #(
  parameter int NUM_W = 10,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             last,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = (NUM_W > 1) ? $clog2(NUM_W) : 1;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] q_q;
  logic [CW-1:0]    cnt_q;
  logic             act_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, q_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign last  = act_q && (cnt_q == CW'(NUM_W - 1));
  assign quo   = q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '1;
      q_q   <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      rem_q <= '0;
      den_q <= (den == '0) ? DEN_W'(1) : den;
      q_q   <= num;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (fits) begin
        rem_q <= DEN_W'(trial - {1'b0, den_q});
        q_q   <= {q_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q + 1'b1;
      if (last) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dll_tune_ctrl.sv
module dll_tune_ctrl
  import dll_tune_pkg::*;
#(
  parameter bit          PHY_NEW  = 1'b1,
  parameter int          DLY_W    = 10,
  parameter int          DIV_W    = 8,
  parameter int          STEP_W   = 6,
  parameter int          CNT_W    = 4,
  parameter int          STEP_LSB = 16,
  parameter int          CNT_LSB  = 8,
  parameter int          TO_TICKS = 32,
  parameter logic [31:0] DLL_RST  = 32'h4000_0009,
  parameter logic [31:0] TUNE_RST = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hs_clk,
  input  logic             dll_lock,
  input  logic [DLY_W-1:0] dly_val,
  input  logic [DIV_W-1:0] div_val,
  input  logic [CNT_W-1:0] pass_cnt,
  input  logic             tick,
  output logic [31:0]      dll_ctrl,
  output logic [31:0]      tune_ctrl,
  output logic             done,
  output logic             err
);
  localparam logic [STEP_W-1:0] STEP_MAX = '1;

  seq_state_t       st_q;
  logic             st_idle;
  logic [31:0]      dll_q, tune_q, dll_next, tune_next;
  logic             done_q, err_q;
  logic             to_hit, div_load, div_last;
  logic [DLY_W-1:0] quo;
  logic [STEP_W-1:0] step;

  assign st_idle  = (st_q == ST_IDLE);
  assign div_load = (st_q == ST_LOCK) && dll_lock;

  dll_word_gen #(.PHY_NEW(PHY_NEW)) u_word (
    .cur(dll_q),
    .nxt(dll_next)
  );

  lock_timer #(.TO_TICKS(TO_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (st_idle),
    .run    (st_q == ST_LOCK),
    .tick   (tick),
    .lock   (dll_lock),
    .expired(to_hit)
  );

  tune_divider #(.NUM_W(DLY_W), .DEN_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (div_load),
    .num  (dly_val),
    .den  (div_val),
    .last (div_last),
    .quo  (quo)
  );

  generate
    if (DLY_W > STEP_W) begin : g_clamp
      assign step = (quo > DLY_W'(STEP_MAX)) ? STEP_MAX : quo[STEP_W-1:0];
    end else begin : g_wide
      assign step = STEP_W'(quo);
    end
  endgenerate

  always_comb begin
    tune_next = tune_q;
    tune_next[STEP_LSB +: STEP_W] = step;
    tune_next[CNT_LSB +: CNT_W]   = pass_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dll_q  <= DLL_RST;
      tune_q <= TUNE_RST;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (!hs_clk) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else if (dll_q[EN_BIT]) begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
            end else begin
              dll_q <= dll_next;
              err_q <= 1'b0;
              st_q  <= ST_LOCK;
            end
          end
        end
        ST_LOCK: begin
          if (dll_lock) begin
            st_q <= ST_DIV;
          end else if (to_hit) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_DIV: begin
          if (div_last) st_q <= ST_FIN;
        end
        default: begin
          tune_q <= tune_next;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign dll_ctrl  = dll_q;
  assign tune_ctrl = tune_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/dll_tune_ctrl_chk.sv
module dll_tune_ctrl_chk #(
  parameter bit PHY_NEW = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        hs_clk,
  input logic        idle,
  input logic [31:0] dll_ctrl,
  input logic [31:0] tune_ctrl,
  input logic        done,
  input logic        err
);
  AST_REFUSE_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && !hs_clk) |=> (done && err && $stable(dll_ctrl) && $stable(tune_ctrl))); // R2

  AST_ENABLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && hs_clk && !dll_ctrl[31]) |=> (dll_ctrl[31] && dll_ctrl[5] && !dll_ctrl[0])); // R3

  AST_PHASE_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && hs_clk && !dll_ctrl[31]) |=> (dll_ctrl[21:16] == 6'h1F && dll_ctrl[29:24] == 6'h1F)); // R4

  AST_UPDATE_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && hs_clk && !dll_ctrl[31]) |=>
      (PHY_NEW ? (dll_ctrl[23] && !dll_ctrl[30]) : dll_ctrl[30])); // R5

  AST_ALREADY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && hs_clk && dll_ctrl[31]) |=> (done && !err && $stable(dll_ctrl) && $stable(tune_ctrl))); // R6

  AST_TUNE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tune_ctrl) |-> done); // R9

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start && idle)) |-> $stable(err)); // R11
endmodule

bind dll_tune_ctrl dll_tune_ctrl_chk #(.PHY_NEW(PHY_NEW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .hs_clk   (hs_clk),
  .idle     (st_idle),
  .dll_ctrl (dll_ctrl),
  .tune_ctrl(tune_ctrl),
  .done     (done),
  .err      (err)
);

// File: tb/dll_tune_ctrl_bench.sv
module dll_tune_ctrl_bench;
  localparam int DLY_W = 6, DIV_W = 4, STEP_W = 3, CNT_W = 3;
  localparam int STEP_LSB = 12, CNT_LSB = 4, TO_TICKS = 3;
  localparam logic [31:0] DRST = 32'h4000_0009;
  localparam logic [31:0] TRST = 32'h5A5A_C33C;

  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, hs_clk = 1'b1, dll_lock = 1'b0, tick = 1'b0;
  logic [DLY_W-1:0] dly_val = '0;
  logic [DIV_W-1:0] div_val = '0;
  logic [CNT_W-1:0] pass_cnt = '0;
  logic [31:0] dll_ctrl, tune_ctrl, dll_old, tune_old;
  logic done, err, done_old, err_old;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dll_tune_ctrl #(.PHY_NEW(1'b1), .DLY_W(DLY_W), .DIV_W(DIV_W), .STEP_W(STEP_W), .CNT_W(CNT_W),
    .STEP_LSB(STEP_LSB), .CNT_LSB(CNT_LSB), .TO_TICKS(TO_TICKS), .DLL_RST(DRST), .TUNE_RST(TRST))
  u_dll_tune_ctrl (.clk(clk), .rst_n(rst_n), .start(start), .hs_clk(hs_clk), .dll_lock(dll_lock),
    .dly_val(dly_val), .div_val(div_val), .pass_cnt(pass_cnt), .tick(tick),
    .dll_ctrl(dll_ctrl), .tune_ctrl(tune_ctrl), .done(done), .err(err));

  dll_tune_ctrl #(.PHY_NEW(1'b0), .DLY_W(DLY_W), .DIV_W(DIV_W), .STEP_W(STEP_W), .CNT_W(CNT_W),
    .STEP_LSB(STEP_LSB), .CNT_LSB(CNT_LSB), .TO_TICKS(TO_TICKS), .DLL_RST(DRST), .TUNE_RST(TRST))
  u_dll_tune_ctrl_old (.clk(clk), .rst_n(rst_n), .start(start), .hs_clk(hs_clk), .dll_lock(dll_lock),
    .dly_val(dly_val), .div_val(div_val), .pass_cnt(pass_cnt), .tick(tick),
    .dll_ctrl(dll_old), .tune_ctrl(tune_old), .done(done_old), .err(err_old));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dll(input logic [31:0] r, input bit nw);
    logic [31:0] e = r;
    e[31] = 1'b1; e[5] = 1'b1; e[0] = 1'b0;
    e[21:16] = 6'h1F; e[29:24] = 6'h1F;
    if (nw) begin e[23] = 1'b1; e[30] = 1'b0; end
    else e[30] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] exp_tune(input int d, input int v, input int pc);
    logic [31:0] e = TRST;
    int q = d / ((v == 0) ? 1 : v);
    if (q > (1 << STEP_W) - 1) q = (1 << STEP_W) - 1;
    e[STEP_LSB +: STEP_W] = STEP_W'(q);
    e[CNT_LSB +: CNT_W] = CNT_W'(pc);
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0; dll_lock = 1'b0; tick = 1'b0; hs_clk = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // start pulse sampled on the next rising edge; returns at the following falling edge
  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  // counts rising edges from the first one that samples lock until done is seen
  task automatic wait_done(output int n);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (done && n == 0) n = i;
      if (n != 0) i = 41;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    do_reset();
    @(negedge clk);
    check(dll_ctrl == DRST, "R1 dll reset", dll_ctrl, DRST);
    check(tune_ctrl == TRST, "R1 tune reset", tune_ctrl, TRST);
    check(!done && !err, "R1 flags reset", {30'd0, done, err}, 32'd0);

    // R2 refusal with the slow clock
    hs_clk = 1'b0;
    pulse_start();
    check(done && err, "R2 refuse flags", {30'd0, done, err}, 32'd3);
    check(dll_ctrl == DRST, "R2 dll untouched", dll_ctrl, DRST);
    check(tune_ctrl == TRST, "R2 tune untouched", tune_ctrl, TRST);
    @(negedge clk);
    check(!done && err, "R11 pulse and hold", {30'd0, done, err}, 32'd1);
    hs_clk = 1'b1;

    // R7 timeout, one tick short then expiry
    do_reset();
    pulse_start();
    check(dll_ctrl == exp_dll(DRST, 1'b1), "R3 R4 R5 new word", dll_ctrl, exp_dll(DRST, 1'b1));
    check(dll_old == exp_dll(DRST, 1'b0), "R5 old word", dll_old, exp_dll(DRST, 1'b0));
    for (int t = 0; t < TO_TICKS - 1; t++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    check(!done, "R7 no early timeout", {31'd0, done}, 32'd0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check(done && err, "R7 timeout flags", {30'd0, done, err}, 32'd3);
    check(tune_ctrl == TRST, "R7 tune unchanged", tune_ctrl, TRST);

    // R6 no-op once enabled; also clears err per R11
    pulse_start();
    check(done && !err, "R6 no-op flags", {30'd0, done, err}, 32'd2);
    check(dll_ctrl == exp_dll(DRST, 1'b1), "R6 dll unchanged", dll_ctrl, exp_dll(DRST, 1'b1));
    check(tune_ctrl == TRST, "R6 tune unchanged", tune_ctrl, TRST);

    // R7 lock beats the final tick
    do_reset();
    dly_val = 6'd45; div_val = 4'd9; pass_cnt = 3'd6;
    pulse_start();
    for (int t = 0; t < TO_TICKS - 1; t++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    tick = 1'b1; dll_lock = 1'b1;
    wait_done(n);
    tick = 1'b0;
    check(n == DLY_W + 2 && !err, "R7 lock priority", n, DLY_W + 2);
    check(tune_ctrl == exp_tune(45, 9, 6), "R8 R9 after race", tune_ctrl, exp_tune(45, 9, 6));

    // sweep every delay against every divider
    for (int d = 0; d < (1 << DLY_W); d++) begin
      for (int v = 0; v < (1 << DIV_W); v++) begin
        do_reset();
        dly_val = DLY_W'(d); div_val = DIV_W'(v); pass_cnt = CNT_W'(d + v);
        pulse_start();
        dll_lock = 1'b1;
        wait_done(n);
        dll_lock = 1'b0;
        check(n == DLY_W + 2, "R10 latency", n, DLY_W + 2);
        check(!err, "R10 err clear", {31'd0, err}, 32'd0);
        check(tune_ctrl == exp_tune(d, v, d + v), "R8 R9 tune word", tune_ctrl, exp_tune(d, v, d + v));
        @(negedge clk);
        check(!done, "R11 done one cycle", {31'd0, done}, 32'd0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule